// File: doc/BRIEF.md
# Sensor Pixel Stream Capture

This block sits directly behind the parallel output of an image sensor and runs in the sensor's pixel clock domain. Every cycle the sensor presents one 12-bit sample together with a frame-qualifier and a line-qualifier. The block keeps a sample only when both qualifiers are high in the same cycle. Each kept sample leaves the block with its column and row position, a start-of-frame flag and an end-of-line flag. The block tells the two kinds of blanking apart. With the frame qualifier low the sensor is between frames, and the row and column positions return to zero. With the frame qualifier high and the line qualifier low the sensor is between lines, and only the column position returns to zero.

Pixels leave on a plain strobe, `pix_valid`, with no ready input. A sensor cannot be stalled, so the block has no back-pressure. A consumer must take every pixel in the cycle it is strobed, at most one per clock. To flag the last pixel of a line, the block holds each sample in a register for one cycle and looks at the qualifiers that follow it. Each output therefore appears two rising edges after its sample was presented. The block also reports the pixel count of the most recent completed line and the line count of the most recent completed frame. After reset it waits for a clean rising edge of the frame qualifier, so a frame already in progress is dropped.

Top module: `pix_capture`

## Requirements
- R1: A sample presented with `sns_fv`=1 and `sns_lv`=1 in the same cycle appears on `pix_data` with `pix_valid`=1 exactly two rising edges later. Samples come out in the order they were presented, and none is lost.
- R2: Samples presented while `sns_fv`=0 never produce `pix_valid`, even if `sns_lv` is high.
- R3: Samples presented with `sns_fv`=1 and `sns_lv`=0 never produce `pix_valid`. At least one cycle without `pix_valid` follows every pixel flagged by `pix_eol`.
- R4: `pix_col` is 0 for the first pixel of every line and rises by exactly 1 for each further pixel of that line.
- R5: `pix_row` is 0 for every pixel of the first line of a frame and rises by 1 for each later line of the same frame.
- R6: `pix_sof` is 1 on the first pixel of a frame and 0 on all other pixels. When `pix_sof` is 1, `pix_col` and `pix_row` are both 0.
- R7: `pix_eol` is 1 exactly on the last pixel of each line. This includes a line of a single pixel and a line whose `sns_lv` falls in the same cycle as `sns_fv`.
- R8: Once a line ends, `line_width` holds its pixel count. The value changes only after a line end.
- R9: Once a frame ends (falling `sns_fv`), `frame_height` holds the number of lines that frame contained.
- R10: If `sns_fv` is already high when reset is released, that frame produces no pixels and no measurements. Capture starts at the next rising edge of `sns_fv`.
- R11: During reset, `pix_valid`, `pix_sof` and `pix_eol` are 0, and `line_width` and `frame_height` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sns_fv | input | 1 | Frame qualifier from the sensor |
| sns_lv | input | 1 | Line qualifier from the sensor |
| sns_data | input | 12 | Sample from the sensor |
| pix_valid | output | 1 | Strobe: a pixel is on the outputs this cycle |
| pix_data | output | 12 | Pixel sample |
| pix_col | output | 12 | Column of the pixel within its line |
| pix_row | output | 11 | Row of the pixel within its frame |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of a line |
| line_width | output | 12 | Pixel count of the last completed line |
| frame_height | output | 11 | Line count of the last completed frame |

## Verification
Some properties are checked on every cycle. The flags never appear without the strobe, and a start of frame always sits at column 0 and row 0. Columns step by one between pixels of the same line. A blank cycle always follows a line end. The measured width moves only after a line end. Other properties need whole scenarios and are shown only by the bench. These are that exactly the qualified samples survive, in order and with two cycles of latency, that row numbering and the measured height match the frames that were driven, and that a frame already in progress at reset is dropped entirely.

// File: rtl/pix_cap_pkg.sv
package pix_cap_pkg;
  localparam int unsigned SNS_DATA_W = 12;
  localparam int unsigned SNS_COL_W  = 12;
  localparam int unsigned SNS_ROW_W  = 11;

  typedef struct packed {
    logic fv;
    logic lv;
  } sync_pair_t;
endpackage

// File: rtl/pix_sync_stage.sv
module pix_sync_stage
  import pix_cap_pkg::*;
#(
  parameter int unsigned DATA_W = SNS_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  sync_pair_t        sync_in,
  input  logic [DATA_W-1:0] data_in,
  output sync_pair_t        sync_q,
  output logic [DATA_W-1:0] data_q,
  output logic              armed,
  output logic              fv_rise
);
  // frame qualifier register resets high so a frame already running at reset
  // release is not mistaken for a fresh start
  assign fv_rise = sync_in.fv & ~sync_q.fv;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '{fv: 1'b1, lv: 1'b0};
      data_q <= '0;
      armed  <= 1'b0;
    end else begin
      sync_q <= sync_in;
      data_q <= data_in;
      if (fv_rise) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pix_pos_counter.sv
module pix_pos_counter #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fv_q,
  input  logic             lv_q,
  input  logic             fv_rise,
  input  logic             pix_v,
  input  logic             line_end,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             sof_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      row      <= '0;
      sof_pend <= 1'b0;
    end else begin
      // horizontal blanking clears the column position
      if (!lv_q || !fv_q)      col <= '0;
      else if (pix_v)          col <= line_end ? '0 : col + 1'b1;
      // vertical blanking clears the row position
      if (!fv_q)               row <= '0;
      else if (line_end)       row <= row + 1'b1;
      if (fv_rise)             sof_pend <= 1'b1;
      else if (pix_v)          sof_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_dim_meter.sv
module pix_dim_meter #(
  parameter int unsigned COL_W = 12,
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_end,
  input  logic             frame_end,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] width_o,
  output logic [ROW_W-1:0] height_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      width_o  <= '0;
      height_o <= '0;
    end else begin
      if (line_end)  width_o  <= col + 1'b1;
      if (frame_end) height_o <= row + {{(ROW_W-1){1'b0}}, line_end};
    end
  end

  assert_width_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(line_end) |-> $stable(width_o));
endmodule

// File: rtl/pix_capture.sv
module pix_capture
  import pix_cap_pkg::*;
#(
  parameter int unsigned DATA_W = SNS_DATA_W,
  parameter int unsigned COL_W  = SNS_COL_W,
  parameter int unsigned ROW_W  = SNS_ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sns_fv,
  input  logic              sns_lv,
  input  logic [DATA_W-1:0] sns_data,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic [COL_W-1:0]  pix_col,
  output logic [ROW_W-1:0]  pix_row,
  output logic              pix_sof,
  output logic              pix_eol,
  output logic [COL_W-1:0]  line_width,
  output logic [ROW_W-1:0]  frame_height
);
  sync_pair_t        sync_in, sync_q;
  logic [DATA_W-1:0] data_q;
  logic              armed, fv_rise;
  logic              pix_v, line_end, frame_end;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic              sof_pend;

  assign sync_in = '{fv: sns_fv, lv: sns_lv};

  pix_sync_stage #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .sync_in(sync_in), .data_in(sns_data),
    .sync_q(sync_q), .data_q(data_q), .armed(armed), .fv_rise(fv_rise)
  );

  // the held sample is the last of its line when the live qualifiers drop
  assign pix_v     = sync_q.fv & sync_q.lv & armed;
  assign line_end  = pix_v & ~(sns_fv & sns_lv);
  assign frame_end = sync_q.fv & ~sns_fv & armed;

  pix_pos_counter #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pos (
    .clk(clk), .rst(rst), .fv_q(sync_q.fv), .lv_q(sync_q.lv),
    .fv_rise(fv_rise), .pix_v(pix_v), .line_end(line_end),
    .col(col), .row(row), .sof_pend(sof_pend)
  );

  pix_dim_meter #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dim (
    .clk(clk), .rst(rst), .line_end(line_end), .frame_end(frame_end),
    .col(col), .row(row), .width_o(line_width), .height_o(frame_height)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_col   <= '0;
      pix_row   <= '0;
      pix_sof   <= 1'b0;
      pix_eol   <= 1'b0;
    end else begin
      pix_valid <= pix_v;
      pix_data  <= data_q;
      pix_col   <= col;
      pix_row   <= row;
      pix_sof   <= pix_v & sof_pend;
      pix_eol   <= line_end;
    end
  end

  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_sof || pix_eol) |-> pix_valid);
  assert_sof_origin_R6: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> (pix_col == '0 && pix_row == '0));
  assert_col_step_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_sof && $past(pix_valid) && !$past(pix_eol))
      |-> pix_col == $past(pix_col) + 1'b1);
  assert_gap_after_eol_R3: assert property (@(posedge clk) disable iff (rst)
    pix_eol |=> !pix_valid);
endmodule

// File: tb/pix_capture_bench.sv
`timescale 1ns/1ps
module pix_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sns_fv = 1'b0, sns_lv = 1'b0;
  logic [11:0] sns_data = '0;
  logic        pix_valid, pix_sof, pix_eol;
  logic [11:0] pix_data, pix_col, line_width;
  logic [10:0] pix_row, frame_height;

  always #2.5 clk = ~clk;

  pix_capture u_pix_capture (
    .clk(clk), .rst(rst), .sns_fv(sns_fv), .sns_lv(sns_lv), .sns_data(sns_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_col(pix_col),
    .pix_row(pix_row), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .line_width(line_width), .frame_height(frame_height)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] q_d [0:8191];
  int          q_c [0:8191];
  int          q_r [0:8191];
  bit          q_s [0:8191];
  bit          q_e [0:8191];
  int wr = 0, rd = 0;
  int exp_w = 0, exp_h = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // output scoreboard, sampled away from the rising edge
  always @(negedge clk) begin
    if (!rst && pix_valid) begin
      if (rd == wr) chk(0, "R2/R3/R10", "unexpected pixel", 1, 0);
      else begin
        chk(pix_data == q_d[rd], "R1", "data", int'(pix_data), int'(q_d[rd]));
        chk(int'(pix_col) == q_c[rd], "R4", "column", int'(pix_col), q_c[rd]);
        chk(int'(pix_row) == q_r[rd], "R5", "row", int'(pix_row), q_r[rd]);
        chk(pix_sof == q_s[rd], "R6", "sof", int'(pix_sof), int'(q_s[rd]));
        chk(pix_eol == q_e[rd], "R7", "eol", int'(pix_eol), int'(q_e[rd]));
        rd++;
      end
    end
  end

  task automatic tick(input logic f, input logic l, input logic [11:0] d);
    sns_fv = f; sns_lv = l; sns_data = d;
    @(negedge clk);
  endtask

  // one frame: nl lines, fixed width wfix (0 = random), hb/vb blanking
  task automatic frame(input int nl, input int wfix, input int hb, input int vb,
                       input bit tail_fall, input bit stray);
    int w;
    tick(1, 0, 12'($urandom));
    for (int l = 0; l < nl; l++) begin
      w = (wfix > 0) ? wfix : 1 + int'($urandom % 20);
      for (int i = 0; i < w; i++) begin
        logic [11:0] d = 12'($urandom);
        q_d[wr] = d; q_c[wr] = i; q_r[wr] = l;
        q_s[wr] = (l == 0 && i == 0); q_e[wr] = (i == w - 1);
        wr++;
        tick(1, 1, d);
      end
      if (!(tail_fall && l == nl - 1))
        for (int b = 0; b < hb; b++) tick(1, 0, 12'($urandom));
    end
    exp_w = w; exp_h = nl;
    for (int b = 0; b < vb; b++) tick(0, stray ? 1'($urandom) : 1'b0, 12'($urandom));
    chk(int'(line_width) == exp_w, "R8", "line width", int'(line_width), exp_w);
    chk(int'(frame_height) == exp_h, "R9", "frame height", int'(frame_height), exp_h);
  endtask

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    // R11: reset state while the sensor is already mid-frame
    tick(1, 1, 12'h123);
    tick(1, 1, 12'h456);
    chk(!pix_valid && !pix_sof && !pix_eol, "R11", "flags in reset",
        int'(pix_valid), 0);
    chk(line_width == 0 && frame_height == 0, "R11", "measures in reset",
        int'(line_width), 0);
    // R10: release reset inside a running frame; nothing may be captured
    rst = 1'b0;
    for (int l = 0; l < 3; l++) begin
      for (int i = 0; i < 5; i++) tick(1, 1, 12'($urandom));
      tick(1, 0, 12'h0);
    end
    for (int b = 0; b < 6; b++) tick(0, 0, 12'h0);
    chk(line_width == 0, "R10", "width after partial frame", int'(line_width), 0);
    chk(frame_height == 0, "R10", "height after partial frame", int'(frame_height), 0);
    // directed corners
    frame(4, 1, 1, 4, 0, 0);   // R7: single-pixel lines, minimal gaps
    frame(3, 7, 2, 5, 1, 0);   // R7: last line ends with the frame
    frame(2, 0, 3, 8, 0, 1);   // R2: line qualifier pulses in vertical blanking
    frame(1, 20, 1, 3, 1, 1);
    // random frames
    for (int k = 0; k < 40; k++)
      frame(1 + int'($urandom % 8), 0, 1 + int'($urandom % 4),
            3 + int'($urandom % 6), 1'($urandom), 1'($urandom));
    repeat (4) @(negedge clk);
    chk(rd == wr, "R1", "all pixels delivered", rd, wr);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule